// File: doc/BRIEF.md
# Infrared Carrier Modulator Transmitter

This block drives an infrared emitter line. A carrier generator makes a square wave whose high and low durations are counted in ticks of an external clock-enable input (the prescaled modulator clock). A mark/space modulator then gates that carrier. During a mark the line shows the carrier, or a steady active level. During a space it sits at the inactive level. Each mark/space pair forms one modulation cycle, and an end-of-cycle flag lets software reload timing values for the next symbol.

There are four operating modes. In direct mode the modulator is off and a software bit sets the line level. In time mode the mark is carrier-gated and mark/space are counted in units of eight ticks. Baseband mode uses the same time base but holds the line steadily active during the mark. In frequency-shift mode mark/space are counted in whole carrier cycles, and two carrier data sets alternate from one cycle to the next. Configuration arrives on plain level inputs and single-cycle write strobes.

Top module: `ir_mod_tx`

## Requirements
- R1: The mode input selects time (4'h1), frequency-shift (4'h5) or baseband (4'h9). Every other value, including 4'h0, is direct mode. In direct mode, with `out_en` high, `ir_out` equals `sw_level`.
- R2: While `out_en` is low, `ir_out` is 0 in every mode.
- R3: In the modulating modes the active level is `pol_high` and the inactive level is its complement.
- R4: The carrier starts high when modulation starts. It stays high for `hi` ticks and then low for `lo` ticks, repeating, with legal counts from 1 to 255. `car1_wr`/`car2_wr` load `car_hi`/`car_lo` into the primary/secondary set at once.
- R5: In time mode a cycle is a mark of (mark+1)×8 ticks that shows the carrier, followed by a space of space×8 ticks at the inactive level. Time mode assumes primary hi+lo = 8.
- R6: In baseband mode the mark is (mark+1)×8 ticks at a steady active level, and the space is space×8 ticks.
- R7: In frequency-shift mode the mark lasts (mark+1) carrier cycles and the space lasts space carrier cycles. The first cycle uses the primary set, and the set alternates at every cycle end.
- R8: `eoc_flag` sets on the first clock that leaves direct mode and at every cycle-end reload. It clears on `eoc_clr`, and a set in the same clock wins. `irq` is `eoc_flag` AND `irq_en`.
- R9: A `ms_wr` strobe loads `mark_in`/`space_in` into holding registers. These values take effect only at the next start or cycle-end reload.
- R10: If `ext_space` is high at a reload, the next cycle keeps its length but stays inactive for its whole mark.
- R11: Reset leaves `eoc_flag` at 0, both carrier sets at hi=lo=1, and the held mark and space at 0.
- R12: A space count of 0 makes a cycle consist of the mark alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Modulator clock enable |
| mode | input | 4 | Operating mode code |
| out_en | input | 1 | Output enable |
| pol_high | input | 1 | 1: active-high output, 0: active-low |
| sw_level | input | 1 | Output level in direct mode |
| ext_space | input | 1 | Suppress the mark of following cycles |
| irq_en | input | 1 | Interrupt enable |
| car1_wr | input | 1 | Write strobe, primary carrier set |
| car2_wr | input | 1 | Write strobe, secondary carrier set |
| car_hi | input | 8 | Carrier high count to write |
| car_lo | input | 8 | Carrier low count to write |
| ms_wr | input | 1 | Write strobe, mark/space holding registers |
| mark_in | input | 16 | Mark count to write |
| space_in | input | 16 | Space count to write |
| eoc_clr | input | 1 | Clear strobe for the end-of-cycle flag |
| ir_out | output | 1 | Infrared output line |
| eoc_flag | output | 1 | End-of-cycle flag |
| irq | output | 1 | Interrupt request |

## Verification
A table drives every modulating mode with different mark/space counts, carrier counts, tick rates (every clock, every other clock) and both polarities. For each run it measures the length and active time of two consecutive cycles. Cycle length separates the eight-tick time base from the carrier-cycle time base. Active time separates carrier gating from the steady baseband level and primary from secondary carrier sets. Directed runs cover reset defaults, a zero space count, holding-register timing, extended-space suppression, direct control and flag/interrupt behaviour.

// File: rtl/ir_mod_pkg.sv
// Shared constants for the infrared modulator: mode codes and modulator phase.
package ir_mod_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_DIRECT = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TIME   = 4'h1;
    localparam logic [MODE_W-1:0] MODE_FSK    = 4'h5;
    localparam logic [MODE_W-1:0] MODE_BASE   = 4'h9;

    typedef enum logic {PH_MARK = 1'b0, PH_SPACE = 1'b1} ms_phase_e;
endpackage

// File: rtl/ir_carrier_gen.sv
// Carrier square-wave generator. Counts hi_cnt ticks high, then lo_cnt ticks
// low, repeating. Assumes counts are nonzero. Held at the start of the high
// phase while not running or on restart. cyc_end pulses on the tick that
// finishes a low phase.
module ir_carrier_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    output logic          car_level,
    output logic          cyc_end
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] ctr;
    logic          lvl;
    logic          hi_last;
    logic          lo_last;

    // Terminal-count detection for both phases.
    always_comb begin
        hi_last = (ctr == hi_cnt - ONE);
        lo_last = (ctr == lo_cnt - ONE);
    end

    assign car_level = lvl;
    assign cyc_end   = run && !restart && tick && !lvl && lo_last;

    // Phase counter and carrier level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            ctr <= '0;
            lvl <= 1'b1;
        end else if (tick) begin
            if (lvl ? hi_last : lo_last) begin
                ctr <= '0;
                lvl <= !lvl;
            end else begin
                ctr <= ctr + ONE;
            end
        end
    end
endmodule

// File: rtl/ir_mark_space.sv
// Mark/space modulator. Holds software-written mark/space values and loads them
// at start or at each cycle end. Counts units of 2**PRE_BITS ticks, or carrier
// cycles in frequency-shift mode. Toggles the carrier set per cycle in that
// mode and applies extended-space suppression per cycle.
// Assumes enable drops for at least one clock between separate runs.
module ir_mark_space
    import ir_mod_pkg::*;
#(
    parameter int MW       = 16,
    parameter int PRE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          fsk_mode,
    input  logic          tick,
    input  logic          car_end,
    input  logic          ms_wr,
    input  logic [MW-1:0] mark_in,
    input  logic [MW-1:0] space_in,
    input  logic          ext_space,
    output logic          start,
    output logic          reload,
    output logic          in_mark,
    output logic          alt_set
);
    localparam logic [PRE_BITS-1:0] PRE_MAX = '1;
    localparam logic [MW-1:0]       ONE     = MW'(1);

    logic [MW-1:0]       mark_sh, space_sh, mark_act, space_act, cnt;
    logic [PRE_BITS-1:0] pre;
    logic                active, supp, unit, mark_done, space_done;
    ms_phase_e           phase;

    // Unit strobe selection and end-of-phase detection.
    always_comb begin
        unit       = fsk_mode ? car_end : (tick && pre == PRE_MAX);
        mark_done  = (phase == PH_MARK)  && unit && (cnt == mark_act);
        space_done = (phase == PH_SPACE) && unit && (cnt == space_act - ONE);
    end

    assign start   = enable && !active;
    assign reload  = enable && active &&
                     ((mark_done && space_act == '0) || space_done);
    assign in_mark = active && (phase == PH_MARK) && !supp;

    // Holding registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_sh  <= '0;
            space_sh <= '0;
        end else if (ms_wr) begin
            mark_sh  <= mark_in;
            space_sh <= space_in;
        end
    end

    // Cycle sequencing: start, phase counting, reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; phase <= PH_MARK; cnt <= '0; pre <= '0;
            mark_act <= '0; space_act <= '0; alt_set <= 1'b0; supp <= 1'b0;
        end else if (!enable) begin
            active <= 1'b0;
        end else if (start || reload) begin
            active    <= 1'b1;
            phase     <= PH_MARK;
            cnt       <= '0;
            mark_act  <= mark_sh;
            space_act <= space_sh;
            supp      <= ext_space;
            alt_set   <= start ? 1'b0 : (fsk_mode && !alt_set);
            if (start)     pre <= '0;
            else if (tick) pre <= pre + 1'b1;
        end else begin
            if (tick) pre <= pre + 1'b1;
            if (mark_done) begin
                phase <= PH_SPACE;
                cnt   <= '0;
            end else if (unit) begin
                cnt <= cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/ir_mod_tx.sv
// Infrared carrier modulator transmitter, top level. Decodes the mode, holds
// both carrier data sets, keeps the end-of-cycle flag and forms the output
// line. Prescaling is external: tick is the modulator clock enable.
module ir_mod_tx
    import ir_mod_pkg::*;
#(
    parameter int CW       = 8,
    parameter int MW       = 16,
    parameter int PRE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    input  logic              out_en,
    input  logic              pol_high,
    input  logic              sw_level,
    input  logic              ext_space,
    input  logic              irq_en,
    input  logic              car1_wr,
    input  logic              car2_wr,
    input  logic [CW-1:0]     car_hi,
    input  logic [CW-1:0]     car_lo,
    input  logic              ms_wr,
    input  logic [MW-1:0]     mark_in,
    input  logic [MW-1:0]     space_in,
    input  logic              eoc_clr,
    output logic              ir_out,
    output logic              eoc_flag,
    output logic              irq
);
    localparam logic [CW-1:0] CNT_RST = CW'(1);

    logic          is_time, is_fsk, is_base, mod_en;
    logic [CW-1:0] hi1, lo1, hi2, lo2, hi_sel, lo_sel;
    logic          start, reload, in_mark, alt_set, car_level, car_end;
    logic          raw_active;

    // Mode decode; unknown codes fall back to direct control.
    always_comb begin
        is_time = (mode == MODE_TIME);
        is_fsk  = (mode == MODE_FSK);
        is_base = (mode == MODE_BASE);
        mod_en  = is_time || is_fsk || is_base;
    end

    // Carrier data sets, written immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi1 <= CNT_RST; lo1 <= CNT_RST; hi2 <= CNT_RST; lo2 <= CNT_RST;
        end else begin
            if (car1_wr) begin hi1 <= car_hi; lo1 <= car_lo; end
            if (car2_wr) begin hi2 <= car_hi; lo2 <= car_lo; end
        end
    end

    // Active carrier set selection.
    always_comb begin
        hi_sel = alt_set ? hi2 : hi1;
        lo_sel = alt_set ? lo2 : lo1;
    end

    ir_carrier_gen #(.CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .run(mod_en && !is_base), .restart(start),
        .tick(tick), .hi_cnt(hi_sel), .lo_cnt(lo_sel),
        .car_level(car_level), .cyc_end(car_end)
    );

    ir_mark_space #(.MW(MW), .PRE_BITS(PRE_BITS)) u_ms (
        .clk(clk), .rst_n(rst_n), .enable(mod_en), .fsk_mode(is_fsk),
        .tick(tick), .car_end(car_end), .ms_wr(ms_wr), .mark_in(mark_in),
        .space_in(space_in), .ext_space(ext_space), .start(start),
        .reload(reload), .in_mark(in_mark), .alt_set(alt_set)
    );

    // End-of-cycle flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               eoc_flag <= 1'b0;
        else if (start || reload) eoc_flag <= 1'b1;
        else if (eoc_clr)         eoc_flag <= 1'b0;
    end

    // Output line: enable, direct level or polarity-mapped modulation.
    always_comb begin
        raw_active = is_base ? in_mark : (in_mark && car_level);
        if (!out_en)      ir_out = 1'b0;
        else if (!mod_en) ir_out = sw_level;
        else              ir_out = raw_active ? pol_high : !pol_high;
    end

    assign irq = eoc_flag && irq_en;
endmodule

// File: rtl/ir_mod_tx_chk.sv
// Property checker for ir_mod_tx, bound into every instance.
module ir_mod_tx_chk
    import ir_mod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              out_en,
    input logic              pol_high,
    input logic              sw_level,
    input logic              irq_en,
    input logic              eoc_clr,
    input logic              start,
    input logic              reload,
    input logic              in_mark,
    input logic              ir_out,
    input logic              eoc_flag,
    input logic              irq
);
    logic modulating;
    assign modulating = (mode == MODE_TIME) || (mode == MODE_FSK) || (mode == MODE_BASE);

    a_r1_direct_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!modulating && out_en) |-> (ir_out == sw_level));
    a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !ir_out);
    a_r5_space_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (modulating && !in_mark && out_en) |-> (ir_out == !pol_high));
    a_r6_base_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BASE && in_mark && out_en) |-> (ir_out == pol_high));
    a_r8_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> eoc_flag);
    a_r8_reload_sets: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> eoc_flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_clr && !start && !reload) |=> !eoc_flag);
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind ir_mod_tx ir_mod_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .out_en(out_en),
    .pol_high(pol_high), .sw_level(sw_level), .irq_en(irq_en),
    .eoc_clr(eoc_clr), .start(start), .reload(reload), .in_mark(in_mark),
    .ir_out(ir_out), .eoc_flag(eoc_flag), .irq(irq)
);

// File: tb/test_ir_mod_tx.sv
`timescale 1ns/1ps
module test_ir_mod_tx;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [3:0]  mode = 4'h0;
    logic        out_en = 1'b0, pol_high = 1'b1, sw_level = 1'b0;
    logic        ext_space = 1'b0, irq_en = 1'b0;
    logic        car1_wr = 1'b0, car2_wr = 1'b0, ms_wr = 1'b0;
    logic [7:0]  car_hi = 8'd1, car_lo = 8'd1;
    logic [15:0] mark_in = '0, space_in = '0;
    logic        mon_clr = 1'b0, man_clr = 1'b0, eoc_clr;
    logic        ir_out, eoc_flag, irq;

    assign eoc_clr = mon_clr | man_clr;
    always #5 clk = !clk;

    ir_mod_tx i_ir_mod_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .out_en(out_en),
        .pol_high(pol_high), .sw_level(sw_level), .ext_space(ext_space),
        .irq_en(irq_en), .car1_wr(car1_wr), .car2_wr(car2_wr), .car_hi(car_hi),
        .car_lo(car_lo), .ms_wr(ms_wr), .mark_in(mark_in), .space_in(space_in),
        .eoc_clr(eoc_clr), .ir_out(ir_out), .eoc_flag(eoc_flag), .irq(irq)
    );

    int checks = 0, fails = 0;
    int evt_cnt = 0, run_len = 0, run_act = 0, last_len = 0, last_act = 0;
    int tdiv = 1;
    bit tphase = 1'b0, auto_clr = 1'b1;

    // Monitor: tick pattern, flag auto-clear, per-cycle length and active time.
    always @(negedge clk) begin
        tphase = !tphase;
        tick   = (tdiv == 1) ? 1'b1 : tphase;
        if (eoc_flag) begin
            last_len = run_len; last_act = run_act; evt_cnt++;
            run_len = 1; run_act = (ir_out == pol_high) ? 1 : 0;
        end else begin
            run_len++;
            if (ir_out == pol_high) run_act++;
        end
        mon_clr = auto_clr & eoc_flag;
    end

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] mark, space;
        logic [7:0]  h1, l1, h2, l2;
        logic [1:0]  td;
        logic        pol;
    } vec_t;

    // Time mode vectors keep h1+l1 = 8.
    localparam vec_t VECS [6] = '{
        '{4'h1, 16'd2, 16'd3, 8'd3, 8'd5, 8'd1, 8'd1, 2'd1, 1'b1},
        '{4'h1, 16'd0, 16'd0, 8'd1, 8'd7, 8'd1, 8'd1, 2'd2, 1'b0},
        '{4'h9, 16'd1, 16'd2, 8'd1, 8'd1, 8'd1, 8'd1, 2'd1, 1'b1},
        '{4'h9, 16'd3, 16'd0, 8'd1, 8'd1, 8'd1, 8'd1, 2'd2, 1'b0},
        '{4'h5, 16'd1, 16'd1, 8'd2, 8'd2, 8'd3, 8'd4, 2'd1, 1'b1},
        '{4'h5, 16'd0, 16'd2, 8'd1, 8'd1, 8'd5, 8'd2, 2'd2, 1'b0}
    };

    function automatic int exp_len(vec_t v, bit sec);
        int per = (v.mode == 4'h5) ? (sec ? int'(v.h2) + int'(v.l2) : int'(v.h1) + int'(v.l1)) : 8;
        return (int'(v.mark) + 1 + int'(v.space)) * per * int'(v.td);
    endfunction

    function automatic int exp_act(vec_t v, bit sec);
        int hi = (v.mode == 4'h5) ? (sec ? int'(v.h2) : int'(v.h1)) :
                 (v.mode == 4'h9) ? 8 : int'(v.h1);
        return (int'(v.mark) + 1) * hi * int'(v.td);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_evt(input int n);
        int tgt = evt_cnt + n;
        int guard = 0;
        while (evt_cnt < tgt && guard < 5000) begin
            @(posedge clk); guard++;
        end
        if (guard >= 5000) begin
            checks++; fails++;
            $display("FAIL timeout: actual %0d expected %0d events", evt_cnt, tgt);
        end
    endtask

    task automatic wr_car(input bit second, input logic [7:0] h, input logic [7:0] l);
        @(negedge clk); car_hi = h; car_lo = l;
        if (second) car2_wr = 1'b1; else car1_wr = 1'b1;
        @(negedge clk); car1_wr = 1'b0; car2_wr = 1'b0;
    endtask

    task automatic wr_ms(input logic [15:0] m, input logic [15:0] s);
        @(negedge clk); mark_in = m; space_in = s; ms_wr = 1'b1;
        @(negedge clk); ms_wr = 1'b0;
    endtask

    task automatic stop_mod();
        @(negedge clk); mode = 4'h0;
        repeat (3) @(negedge clk);
    endtask

    task automatic go(input logic [3:0] m, input int td, input logic pol);
        @(negedge clk); tdiv = td; pol_high = pol; out_en = 1'b1; mode = m;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset ir_out", int'(ir_out), 0);
        check("R11 reset eoc_flag", int'(eoc_flag), 0);
        check("R8 reset irq", int'(irq), 0);
        @(negedge clk); rst_n = 1'b1;

        // R11 defaults: baseband with held mark=0 space=0 -> 8-clock cycles.
        go(4'h9, 1, 1'b1);
        wait_evt(3);
        check("R11 default len", last_len, 8);
        check("R11 default act", last_act, 8);
        stop_mod();
        // R11 default carrier 1/1 in FSK: 4 units of 2 ticks.
        wr_ms(16'd3, 16'd0);
        go(4'h5, 1, 1'b1);
        wait_evt(3);
        check("R11 default carrier len R7", last_len, 8);
        check("R11 default carrier act", last_act, 4);
        stop_mod();

        // Table walk: R4 R5 R6 R7 R12 R3.
        foreach (VECS[i]) begin
            wr_car(1'b0, VECS[i].h1, VECS[i].l1);
            wr_car(1'b1, VECS[i].h2, VECS[i].l2);
            wr_ms(VECS[i].mark, VECS[i].space);
            go(VECS[i].mode, int'(VECS[i].td), VECS[i].pol);
            wait_evt(3);
            check($sformatf("R4 R5 R6 R7 vec%0d len A", i), last_len, exp_len(VECS[i], 1'b1));
            check($sformatf("R3 R12 vec%0d act A", i), last_act, exp_act(VECS[i], 1'b1));
            wait_evt(1);
            check($sformatf("R7 vec%0d len B", i), last_len, exp_len(VECS[i], 1'b0));
            check($sformatf("R7 vec%0d act B", i), last_act, exp_act(VECS[i], 1'b0));
            stop_mod();
        end

        // R9: held values apply only from the next reload.
        wr_ms(16'd0, 16'd1);
        go(4'h9, 1, 1'b1);
        wait_evt(2);
        wr_ms(16'd2, 16'd0);
        wait_evt(1);
        check("R9 current cycle len", last_len, 16);
        check("R9 current cycle act", last_act, 8);
        wait_evt(1);
        check("R9 next cycle len", last_len, 24);
        check("R9 next cycle act", last_act, 24);
        stop_mod();

        // R10: extended space suppresses the mark of the following cycle.
        wr_ms(16'd1, 16'd1);
        go(4'h9, 1, 1'b1);
        wait_evt(2);
        @(negedge clk); ext_space = 1'b1;
        wait_evt(1);
        check("R10 before act", last_act, 16);
        @(negedge clk); ext_space = 1'b0;
        wait_evt(1);
        check("R10 suppressed len", last_len, 24);
        check("R10 suppressed act", last_act, 0);
        wait_evt(1);
        check("R10 restored act", last_act, 16);
        stop_mod();

        // R1 direct control and R2 enable.
        @(negedge clk); out_en = 1'b1; sw_level = 1'b1;
        @(posedge clk); #1 check("R1 direct high", int'(ir_out), 1);
        @(negedge clk); sw_level = 1'b0;
        @(posedge clk); #1 check("R1 direct low", int'(ir_out), 0);
        @(negedge clk); mode = 4'h3; sw_level = 1'b1;
        @(posedge clk); #1 check("R1 unknown code direct", int'(ir_out), 1);
        @(negedge clk); mode = 4'h0; sw_level = 1'b0;
        begin
            int highs = 0;
            @(negedge clk); out_en = 1'b0; pol_high = 1'b1; mode = 4'h9;
            repeat (20) begin
                @(posedge clk); #1 if (ir_out) highs++;
            end
            check("R2 disabled output highs", highs, 0);
        end
        stop_mod();

        // R8 flag, interrupt masking and clear.
        @(negedge clk); auto_clr = 1'b0; irq_en = 1'b1; mode = 4'h9;
        @(posedge clk); #1;
        check("R8 start sets flag", int'(eoc_flag), 1);
        check("R8 irq follows flag", int'(irq), 1);
        @(negedge clk); irq_en = 1'b0; mode = 4'h0;
        @(posedge clk); #1 check("R8 irq masked", int'(irq), 0);
        @(negedge clk); man_clr = 1'b1;
        @(negedge clk); man_clr = 1'b0;
        @(posedge clk); #1 check("R8 flag cleared", int'(eoc_flag), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule